// File: doc/BRIEF.md
# Two-Wire Multi-Master Bus Monitor

This block observes the clock and data lines of a shared two-wire serial bus on which several masters may compete. It recognises bus conditions (a clock-high falling data edge opens a transfer, a clock-high rising data edge closes one). It keeps one sticky flag for each kind of condition and derives from them whether another master may take the bus. When an interrupt enable is set, a closing condition raises a one-cycle interrupt, so firmware that found the bus occupied learns when it frees up.

While this device is driving the bus, the block compares the sampled data level with the level the device means to drive. When the device releases data high on a high clock but the line reads low, another master has won arbitration, and a sticky collision flag is raised. The comparison runs in five bus phases, named by a phase code from the transfer sequencer: address, data, opening condition, repeated opening condition and acknowledge. The line inputs must already be synchronised to `clk`. Pin drivers and byte shifting live elsewhere.

The bus-state machine has four states. S_OFF means the monitor is disabled. S_IDLE means no flag is set. S_BUSY means the opening flag is set. S_STOPPED means the closing flag is set. Any state goes to S_OFF when `en` is low. Otherwise an opening condition leads to S_BUSY, and a repeated opening condition stays there. A closing condition leads to S_STOPPED. With no condition, S_OFF goes to S_IDLE and every other state holds. The arbitration machine has two states. A_CLEAN goes to A_LOST on a mismatch. A_LOST goes back to A_CLEAN on `col_clr` when there is no mismatch in the same cycle.

Top module: `tw_bus_watch`

## Requirements
- R1: Reset clears both condition flags, the collision flag and the interrupt. While `en` is low, both condition flags read 0 from the first clock edge after `en` falls.
- R2: An opening condition is `sda_in` going 1 to 0 between two consecutive clock samples while `scl_in` is 1 in both. It sets `start_seen` and clears `stop_seen` at that clock edge. A repeat of the condition keeps `start_seen` set.
- R3: A closing condition is `sda_in` going 0 to 1 between two consecutive clock samples while `scl_in` is 1 in both. It sets `stop_seen` and clears `start_seen` at that clock edge.
- R4: Data changes while `scl_in` is 0, and changes of `scl_in` itself, leave both condition flags unchanged.
- R5: `bus_free` is 1 when `stop_seen` is 1, or when both condition flags are 0. Otherwise it is 0.
- R6: With `irq_en` = 1, a closing condition makes `irq` 1 for exactly one cycle, from the same edge that sets `stop_seen`. With `irq_en` = 0, `irq` stays 0.
- R7: Phase codes on `phase` are: 0 none, 1 address, 2 data, 3 opening condition, 4 repeated opening condition, 5 acknowledge, 6 and 7 none. With `en` = 1, `drive_act` = 1, a phase code from 1 to 5, `scl_in` = 1, `sda_drive` = 1 and `sda_in` = 0 all in the same cycle, `col_flag` is 1 after the next edge.
- R8: No other combination sets `col_flag`. This covers phase codes 0, 6 and 7, `scl_in` = 0, `sda_drive` = 0, `drive_act` = 0 and `en` = 0.
- R9: `col_flag` stays set until a cycle with `col_clr` = 1 clears it at the next edge. A mismatch in that same cycle wins, and the flag stays set.
- R10: While `en` is 0, bus conditions change no flag and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Monitor enable |
| scl_in | input | 1 | Synchronised clock-line level |
| sda_in | input | 1 | Synchronised data-line level |
| sda_drive | input | 1 | Data level this device intends (1 = released high) |
| drive_act | input | 1 | This device is currently driving the bus |
| phase | input | 3 | Current transfer phase code (see R7) |
| irq_en | input | 1 | Interrupt enable for closing conditions |
| col_clr | input | 1 | Clears the collision flag |
| start_seen | output | 1 | Sticky opening-condition flag |
| stop_seen | output | 1 | Sticky closing-condition flag |
| bus_free | output | 1 | Bus may be claimed |
| col_flag | output | 1 | Sticky arbitration-lost flag |
| irq | output | 1 | One-cycle interrupt on a closing condition |

## Verification
Each result is registered once, so every result is due one edge after the cycle in which its stimulus is presented. This covers the condition flags, `bus_free`, `irq` and `col_flag`. The bench changes inputs one time unit after a rising edge and reads outputs one time unit after the following edge. It also reads `irq` one more edge later to confirm that the pulse has ended. The collision sweep goes through all 256 combinations of phase, drive, clock and data levels. Each combination gets a clearing cycle, a stimulus cycle and a quiet cycle, so each expected flag value belongs to exactly one stimulus.

// File: rtl/tw_mon_pkg.sv
package tw_mon_pkg;
    localparam int PHASE_W = 3;
    localparam logic [PHASE_W-1:0] PH_FIRST = 3'd1;  // address
    localparam logic [PHASE_W-1:0] PH_LAST  = 3'd5;  // acknowledge

    typedef enum logic [1:0] {
        S_OFF,
        S_IDLE,
        S_BUSY,
        S_STOPPED
    } bus_state_e;

    typedef enum logic {
        A_CLEAN,
        A_LOST
    } arb_state_e;

    function automatic logic phase_checked(input logic [PHASE_W-1:0] p);
        return (p >= PH_FIRST) && (p <= PH_LAST);
    endfunction
endpackage

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Clock high on both samples; the data edge decides the kind.
    always_comb begin
        start_det = scl_q && scl && sda_q && !sda;
        stop_det  = scl_q && scl && !sda_q && sda;
    end
endmodule

// File: rtl/tw_bus_fsm.sv
module tw_bus_fsm
    import tw_mon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start_det,
    input  logic stop_det,
    input  logic irq_en,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq
);
    bus_state_e state, state_nx;
    logic       irq_q;

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = S_OFF;
        end else begin
            unique case (state)
                S_OFF:     state_nx = S_IDLE;
                S_IDLE:    state_nx = S_IDLE;
                S_BUSY:    state_nx = S_BUSY;
                S_STOPPED: state_nx = S_STOPPED;
            endcase
            if (start_det)     state_nx = S_BUSY;
            else if (stop_det) state_nx = S_STOPPED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_OFF;
            irq_q <= 1'b0;
        end else begin
            state <= state_nx;
            irq_q <= en && irq_en && stop_det;
        end
    end

    always_comb begin
        start_seen = 1'b0;
        stop_seen  = 1'b0;
        unique case (state)
            S_OFF:     ;
            S_IDLE:    ;
            S_BUSY:    start_seen = 1'b1;
            S_STOPPED: stop_seen  = 1'b1;
        endcase
        bus_free = stop_seen || (!start_seen && !stop_seen);
        irq      = irq_q;
    end

    // R2: an enabled opening condition shows as start_seen after the edge
    a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        en && start_det |=> start_seen && !stop_seen);

    // R3: an enabled closing condition shows as stop_seen after the edge
    a_r3_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
        en && stop_det |=> stop_seen && !start_seen);

    // R4: with no condition, an enabled monitor keeps its state
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state != S_OFF && en && !start_det && !stop_det |=> $stable(state));
endmodule

// File: rtl/tw_arb_check.sv
module tw_arb_check
    import tw_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               drive_act,
    input  logic [PHASE_W-1:0] phase,
    input  logic               scl,
    input  logic               sda,
    input  logic               sda_drive,
    input  logic               col_clr,
    output logic               col_flag
);
    arb_state_e astate, astate_nx;
    logic       mismatch;

    always_comb begin
        mismatch = en && drive_act && phase_checked(phase)
                   && scl && sda_drive && !sda;
    end

    always_comb begin
        astate_nx = astate;
        unique case (astate)
            A_CLEAN: if (mismatch) astate_nx = A_LOST;
            A_LOST:  if (col_clr && !mismatch) astate_nx = A_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) astate <= A_CLEAN;
        else        astate <= astate_nx;
    end

    always_comb col_flag = (astate == A_LOST);

    // R7: a detected mismatch raises the flag at the next edge
    a_r7_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> col_flag);

    // R8: a released line reading high never raises the flag
    a_r8_no_false_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !col_flag && sda |=> !col_flag);

    // R9: the flag holds without a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        col_flag && !col_clr |=> col_flag);
endmodule

// File: rtl/tw_bus_watch.sv
module tw_bus_watch
    import tw_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic               sda_drive,
    input  logic               drive_act,
    input  logic [PHASE_W-1:0] phase,
    input  logic               irq_en,
    input  logic               col_clr,
    output logic               start_seen,
    output logic               stop_seen,
    output logic               bus_free,
    output logic               col_flag,
    output logic               irq
);
    logic start_det;
    logic stop_det;

    tw_cond_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (scl_in),
        .sda       (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .irq_en     (irq_en),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .bus_free   (bus_free),
        .irq        (irq)
    );

    tw_arb_check u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .drive_act (drive_act),
        .phase     (phase),
        .scl       (scl_in),
        .sda       (sda_in),
        .sda_drive (sda_drive),
        .col_clr   (col_clr),
        .col_flag  (col_flag)
    );

    // R1, R10: a disabled monitor shows no condition flag and no interrupt
    a_r1_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !start_seen && !stop_seen && !irq);

    // R6: an interrupt only comes with the closing flag set
    a_r6_irq_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stop_seen && $past(irq_en));
endmodule

// File: tb/sim_tw_bus_watch.sv
`timescale 1ns/1ps
module sim_tw_bus_watch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       sda_drive = 1'b1;
    logic       drive_act = 1'b0;
    logic [2:0] phase = 3'd0;
    logic       irq_en = 1'b0;
    logic       col_clr = 1'b0;
    logic       start_seen, stop_seen, bus_free, col_flag, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tw_bus_watch u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .scl_in(scl_in), .sda_in(sda_in),
        .sda_drive(sda_drive), .drive_act(drive_act), .phase(phase),
        .irq_en(irq_en), .col_clr(col_clr), .start_seen(start_seen),
        .stop_seen(stop_seen), .bus_free(bus_free), .col_flag(col_flag),
        .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic flags(input string req, input logic s, input logic p);
        check({req, " start_seen"}, start_seen, s);
        check({req, " stop_seen"}, stop_seen, p);
        check({req, " bus_free (R5)"}, bus_free, p || (!s && !p));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        flags("R1 reset", 1'b0, 1'b0);
        check("R1 reset col_flag", col_flag, 1'b0);
        check("R1 reset irq", irq, 1'b0);

        en = 1'b1; irq_en = 1'b1;
        tick();
        flags("R1 enabled idle", 1'b0, 1'b0);

        sda_in = 1'b0; tick();                       // opening condition
        flags("R2 open", 1'b1, 1'b0);
        check("R6 no irq on open", irq, 1'b0);

        scl_in = 1'b0; tick();
        sda_in = 1'b1; tick();
        sda_in = 1'b0; tick();
        flags("R4 data under low clock", 1'b1, 1'b0);
        scl_in = 1'b1; tick();
        flags("R4 clock rise", 1'b1, 1'b0);

        scl_in = 1'b0; tick();                       // repeated opening
        sda_in = 1'b1; tick();
        scl_in = 1'b1; tick();
        flags("R4 clock rise data high", 1'b1, 1'b0);
        sda_in = 1'b0; tick();
        flags("R2 repeated open", 1'b1, 1'b0);

        scl_in = 1'b0; tick();                       // closing condition
        scl_in = 1'b1; tick();
        sda_in = 1'b1; tick();
        flags("R3 close", 1'b0, 1'b1);
        check("R6 irq pulse", irq, 1'b1);
        tick();
        check("R6 irq one cycle", irq, 1'b0);
        flags("R3 close held", 1'b0, 1'b1);

        irq_en = 1'b0;
        sda_in = 1'b0; tick();
        flags("R2 open after close", 1'b1, 1'b0);
        sda_in = 1'b1; tick();
        flags("R3 close again", 1'b0, 1'b1);
        check("R6 irq masked", irq, 1'b0);

        irq_en = 1'b1;
        sda_in = 1'b0; tick();
        en = 1'b0; tick();
        flags("R1 disable clears", 1'b0, 1'b0);
        sda_in = 1'b1; tick();
        flags("R10 close ignored", 1'b0, 1'b0);
        check("R10 no irq", irq, 1'b0);
        sda_in = 1'b0; tick();
        flags("R10 open ignored", 1'b0, 1'b0);
        en = 1'b1; tick();
        flags("R1 re-enable idle", 1'b0, 1'b0);

        // R7/R8: sweep all phase, drive and level combinations
        for (int k = 0; k < 256; k++) begin
            logic [2:0] p;
            logic e, a, d, s, q, exp;
            p = k[2:0]; a = k[3]; d = k[4]; s = k[5]; q = k[6]; e = k[7];
            col_clr = 1'b1; drive_act = 1'b0; en = 1'b1; tick();
            col_clr = 1'b0;
            en = e; phase = p; drive_act = a; sda_drive = d; scl_in = s; sda_in = q;
            tick();
            exp = e && a && (p >= 3'd1) && (p <= 3'd5) && s && d && !q;
            check(exp ? "R7 sweep set" : "R8 sweep quiet", col_flag, exp);
            drive_act = 1'b0; en = 1'b1; tick();
            check("R9 sweep sticky", col_flag, exp);
        end

        // R7: second master pulls data low in each of the five phases
        for (int p = 1; p <= 5; p++) begin
            col_clr = 1'b1; drive_act = 1'b0; scl_in = 1'b0; sda_in = 1'b1; tick();
            col_clr = 1'b0; check("R9 clear", col_flag, 1'b0);
            drive_act = 1'b1; sda_drive = 1'b1; phase = p[2:0]; scl_in = 1'b1; tick();
            check("R7 released high, no loss", col_flag, 1'b0);
            sda_in = 1'b0; tick();
            check($sformatf("R7 loss in phase %0d", p), col_flag, 1'b1);
        end

        // R9: clear together with a fresh mismatch keeps the flag
        col_clr = 1'b1; tick();
        check("R9 set wins over clear", col_flag, 1'b1);
        drive_act = 1'b0; tick();
        check("R9 clear", col_flag, 1'b0);
        col_clr = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule